// File: doc/BRIEF.md
# Compare Output Mode Unit

This unit sits beside a timer counter and turns one compare channel into a waveform pin. Each cycle it compares the timer count against the channel's compare value. When the two first become equal, it raises a one-cycle channel event. The timer also supplies a separate period-match strobe. A 3-bit mode field picks what each of the two events does to a single output flip-flop: set it, clear it, toggle it, or leave it alone. In up/down counting, the count direction also shapes the result.

In up counting, the set/reset mode with a period strobe gives edge-aligned PWM. In up/down counting, the toggle/reset mode gives center-aligned PWM. Mode 0 hands the pin to a software-driven bit. Every channel event also latches an interrupt flag. A strobe clears the flag, and an enable gates it onto the interrupt request.

Top module: `cmp_out_unit`

## Requirements
- R1: The mode field `out_mode` uses these codes. 0 selects the software bit. 1 is set. 2 is toggle/reset. 3 is set/reset. 4 is toggle. 5 is reset. 6 is toggle/set. 7 is reset/set. In each two-part name, the first action belongs to the channel event and the second to the period event.
- R2: In mode 0, `wave_out` equals `sw_out` combinationally, and the flip-flop follows `sw_out`. After leaving mode 0, the output starts from the last software value.
- R3: With `updown` low, a channel event applies the mode's channel action one clock later: set (1, 3), clear (5, 7) or toggle (2, 4, 6).
- R4: A `period_hit` clears the output in modes 2 and 3 and sets it in modes 6 and 7. Modes 1, 4 and 5 ignore it.
- R5: When a channel event and `period_hit` fall in the same cycle, the period action wins.
- R6: With `updown` high, modes 1, 2, 4, 5 and 6 act as in up counting. The toggle modes toggle on channel events in both directions.
- R7: With `updown` high, modes 3 and 7 act on a channel event only while `cnt_down` is high. The event is ignored while `cnt_down` is low.
- R8: A channel event fires only in the first cycle that `cnt` equals `cmp_val`. Holding the equality causes no further action and sets no flag again.
- R9: A channel event sets `cmp_flag`. `flag_clr` clears it. A clear and an event in the same cycle leave the flag set.
- R10: `irq` is high exactly when `cmp_flag` and `irq_en` are both high.
- R11: Reset drives `wave_out` (outside mode 0), `cmp_flag` and `irq` low.
- R12: In up counting with period 8, compare 5 and mode 3, the output is high after the count reaches 5 and low again after the count reaches 8.
- R13: In up/down counting with period 7, compare 4 and mode 2, the low part of each cycle lies around the top of the count. The output goes low at the rising match, stays low through the top and goes high at the falling match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt | input | CW | Timer count |
| cnt_down | input | 1 | 1 while the timer counts down |
| updown | input | 1 | 1 when the timer runs in up/down counting |
| cmp_val | input | CW | Channel compare value |
| period_hit | input | 1 | One-cycle period-register match from the timer |
| out_mode | input | 3 | Output mode code (see R1) |
| sw_out | input | 1 | Software output bit for mode 0 |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the compare flag |
| wave_out | output | 1 | Waveform pin |
| cmp_flag | output | 1 | Compare interrupt flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a cycle where a fresh channel event, a period strobe and a direction-dependent mode all meet. A free-running counter rarely produces that. The bench therefore drives the count, direction and period strobe directly as table vectors. It places the count at the compare value in the same cycle as the strobe. It steps the count off the compare value and back to create fresh events. It pairs each ignored event in modes 3 and 7 with a following cycle whose result depends on the output still holding.

// File: rtl/cmp_out_unit.sv
module cmp_out_unit #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          cnt_down,
  input  logic          updown,
  input  logic [CW-1:0] cmp_val,
  input  logic          period_hit,
  input  logic [2:0]    out_mode,
  input  logic          sw_out,
  input  logic          irq_en,
  input  logic          flag_clr,
  output logic          wave_out,
  output logic          cmp_flag,
  output logic          irq
);

  typedef enum logic [1:0] {ACT_NONE, ACT_SET, ACT_CLR, ACT_TOG} act_e;

  logic eq_now, eq_q, chan_hit, wave_q, rising_ud;
  act_e ch_act, pe_act;

  assign eq_now    = (cnt == cmp_val);
  assign chan_hit  = eq_now && !eq_q;
  assign rising_ud = updown && !cnt_down;

  always_comb begin
    ch_act = ACT_NONE;
    pe_act = ACT_NONE;
    unique case (out_mode)
      3'd1: ch_act = ACT_SET;
      3'd2: begin ch_act = ACT_TOG; pe_act = ACT_CLR; end
      3'd3: begin ch_act = rising_ud ? ACT_NONE : ACT_SET; pe_act = ACT_CLR; end
      3'd4: ch_act = ACT_TOG;
      3'd5: ch_act = ACT_CLR;
      3'd6: begin ch_act = ACT_TOG; pe_act = ACT_SET; end
      3'd7: begin ch_act = rising_ud ? ACT_NONE : ACT_CLR; pe_act = ACT_SET; end
      default: ;
    endcase
  end

  function automatic logic apply(act_e a, logic cur);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TOG: return !cur;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eq_q     <= 1'b0;
      wave_q   <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      eq_q <= eq_now;
      if (out_mode == 3'd0)
        wave_q <= sw_out;
      else if (period_hit && pe_act != ACT_NONE)
        wave_q <= apply(pe_act, wave_q);
      else if (chan_hit)
        wave_q <= apply(ch_act, wave_q);
      if (chan_hit)
        cmp_flag <= 1'b1;
      else if (flag_clr)
        cmp_flag <= 1'b0;
    end
  end

  assign wave_out = (out_mode == 3'd0) ? sw_out : wave_q;
  assign irq      = cmp_flag && irq_en;

endmodule

// File: rtl/cmp_out_unit_chk.sv
module cmp_out_unit_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          cnt_down,
  input logic          updown,
  input logic [CW-1:0] cmp_val,
  input logic          period_hit,
  input logic [2:0]    out_mode,
  input logic          sw_out,
  input logic          irq_en,
  input logic          flag_clr,
  input logic          wave_out,
  input logic          cmp_flag,
  input logic          irq
);

  logic prev_eq, ev;
  always_ff @(posedge clk) prev_eq <= rst_n && (cnt == cmp_val);
  assign ev = (cnt == cmp_val) && !prev_eq;

  a_r9_flag_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> cmp_flag);

  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !ev) |=> !cmp_flag);

  a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cmp_flag && irq_en));

  a_r5_period_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (period_hit && (out_mode == 3'd2 || out_mode == 3'd3)) |=> (out_mode == 3'd0 || !wave_out));

  a_r5_period_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (period_hit && (out_mode == 3'd6 || out_mode == 3'd7)) |=> (out_mode == 3'd0 || wave_out));

  a_r4_period_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (period_hit && !ev && (out_mode == 3'd1 || out_mode == 3'd4 || out_mode == 3'd5))
      |=> (out_mode == 3'd0 || $past(out_mode) != out_mode || $stable(wave_out)));

  a_r7_rising_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (updown && !cnt_down && !period_hit && (out_mode == 3'd3 || out_mode == 3'd7))
      |=> (out_mode == 3'd0 || $past(out_mode) != out_mode || $stable(wave_out)));

  a_r2_mode0_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(out_mode) == 3'd0 && out_mode != 3'd0) |-> wave_out == $past(sw_out));

endmodule

bind cmp_out_unit cmp_out_unit_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_down(cnt_down), .updown(updown),
  .cmp_val(cmp_val), .period_hit(period_hit), .out_mode(out_mode), .sw_out(sw_out),
  .irq_en(irq_en), .flag_clr(flag_clr), .wave_out(wave_out), .cmp_flag(cmp_flag),
  .irq(irq)
);

// File: tb/tb_cmp_out_unit.sv
module tb_cmp_out_unit;
  localparam int CW = 8;
  localparam int NV = 22;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] cnt = '0, cmp_val = 8'd5;
  logic cnt_down = 0, updown = 0, period_hit = 0, sw_out = 0, irq_en = 0, flag_clr = 0;
  logic [2:0] out_mode = 3'd3;
  logic wave_out, cmp_flag, irq;
  int checks = 0, errors = 0;

  always #2 clk = !clk;

  cmp_out_unit #(.CW(CW)) dut (.*);

  // {cnt, cmp, down, updown, period, mode, sw, ie, clr, exp_wave, exp_flag, exp_irq}
  localparam logic [27:0] VEC [NV] = '{
    {8'd0, 8'd5, 1'b0,1'b0,1'b0, 3'd0, 1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0}, // R2
    {8'd1, 8'd5, 1'b0,1'b0,1'b0, 3'd0, 1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0}, // R2
    {8'd5, 8'd5, 1'b0,1'b0,1'b0, 3'd3, 1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1}, // R3 R9 R10
    {8'd5, 8'd5, 1'b0,1'b0,1'b0, 3'd3, 1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0}, // R8 R9
    {8'd8, 8'd5, 1'b0,1'b0,1'b1, 3'd3, 1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0}, // R4
    {8'd5, 8'd5, 1'b0,1'b0,1'b0, 3'd4, 1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1}, // R3
    {8'd6, 8'd5, 1'b0,1'b0,1'b1, 3'd4, 1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0}, // R4 R10
    {8'd5, 8'd5, 1'b0,1'b0,1'b0, 3'd5, 1'b0,1'b0,1'b1, 1'b0,1'b1,1'b0}, // R3 R9
    {8'd0, 8'd5, 1'b0,1'b0,1'b1, 3'd1, 1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0}, // R4
    {8'd5, 8'd5, 1'b0,1'b0,1'b1, 3'd7, 1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1}, // R5
    {8'd7, 8'd5, 1'b0,1'b0,1'b1, 3'd2, 1'b0,1'b1,1'b0, 1'b0,1'b1,1'b1}, // R4
    {8'd8, 8'd5, 1'b0,1'b0,1'b1, 3'd6, 1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1}, // R4
    {8'd5, 8'd5, 1'b0,1'b0,1'b0, 3'd2, 1'b0,1'b1,1'b0, 1'b0,1'b1,1'b1}, // R3
    {8'd6, 8'd5, 1'b0,1'b0,1'b0, 3'd2, 1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0}, // R9
    {8'd5, 8'd5, 1'b0,1'b1,1'b0, 3'd3, 1'b0,1'b1,1'b0, 1'b0,1'b1,1'b1}, // R7
    {8'd4, 8'd5, 1'b1,1'b1,1'b0, 3'd3, 1'b0,1'b1,1'b0, 1'b0,1'b1,1'b1}, // R7
    {8'd5, 8'd5, 1'b1,1'b1,1'b0, 3'd3, 1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1}, // R7
    {8'd4, 8'd5, 1'b1,1'b1,1'b0, 3'd7, 1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1}, // R7
    {8'd5, 8'd5, 1'b0,1'b1,1'b0, 3'd7, 1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1}, // R7
    {8'd4, 8'd5, 1'b1,1'b1,1'b0, 3'd7, 1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1}, // R7
    {8'd5, 8'd5, 1'b1,1'b1,1'b0, 3'd7, 1'b0,1'b1,1'b0, 1'b0,1'b1,1'b1}, // R7
    {8'd0, 8'd5, 1'b0,1'b0,1'b0, 3'd0, 1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0}  // R1 R2
  };

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(logic [CW-1:0] c, logic dn, logic per);
    cnt = c; cnt_down = dn; period_hit = per;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "wave after reset", wave_out, 1'b0);
    check("R11", "flag after reset", cmp_flag, 1'b0);
    check("R11", "irq after reset", irq, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cnt = VEC[i][27:20]; cmp_val = VEC[i][19:12]; cnt_down = VEC[i][11];
      updown = VEC[i][10]; period_hit = VEC[i][9]; out_mode = VEC[i][8:6];
      sw_out = VEC[i][5]; irq_en = VEC[i][4]; flag_clr = VEC[i][3];
      @(negedge clk);
      check("R1-table", $sformatf("vec %0d wave", i), wave_out, VEC[i][2]);
      check("R9-table", $sformatf("vec %0d flag", i), cmp_flag, VEC[i][1]);
      check("R10-table", $sformatf("vec %0d irq", i), irq, VEC[i][0]);
    end
    flag_clr = 0;

    // R12: edge-aligned PWM, two periods
    updown = 0; cmp_val = 8'd5; out_mode = 3'd3;
    for (int p = 0; p < 2; p++)
      for (int c = 0; c <= 8; c++) begin
        step(c[CW-1:0], 1'b0, c == 8);
        check("R12", $sformatf("edge pwm cnt %0d", c), wave_out, (c >= 5 && c < 8));
      end

    // R6: up/down toggle in both directions
    out_mode = 3'd0; sw_out = 0; step(8'd0, 1'b0, 1'b0);
    out_mode = 3'd4; updown = 1; cmp_val = 8'd4;
    for (int k = 1; k < 14; k++) begin
      int c; logic dn;
      c  = (k <= 7) ? k : 14 - k;
      dn = (k > 7);
      step(c[CW-1:0], dn, k == 7);
      check("R6", $sformatf("ud toggle k %0d", k), wave_out, (!dn && c >= 4) || (dn && c > 4));
    end

    // R13: center-aligned PWM, check periods after the first
    out_mode = 3'd0; step(8'd0, 1'b0, 1'b0);
    out_mode = 3'd2;
    for (int k = 0; k < 42; k++) begin
      int ph, c; logic dn;
      ph = k % 14;
      c  = (ph <= 7) ? ph : 14 - ph;
      dn = (ph > 7);
      step(c[CW-1:0], dn, ph == 7);
      if (k >= 14)
        check("R13", $sformatf("center pwm k %0d", k), wave_out, (dn && c <= 4) || (!dn && c < 4));
    end

    // R11: reset mid-run
    updown = 0; out_mode = 3'd1; irq_en = 1; cmp_val = 8'd9;
    step(8'd9, 1'b0, 1'b0);
    check("R9", "flag before reset", cmp_flag, 1'b1);
    rst_n = 0; @(negedge clk);
    check("R11", "wave in reset", wave_out, 1'b0);
    check("R11", "flag in reset", cmp_flag, 1'b0);
    check("R11", "irq in reset", irq, 1'b0);
    rst_n = 1; @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule